// File: doc/BRIEF.md
# External Memory Bus Strobe Sequencer

This block produces the pin-level signals of a multiplexed 8-bit external memory bus for a small microcontroller core. It runs on the oscillator clock. The core hands it one request per slot: a code fetch, a table read from code space, an external data read, an external data write, or nothing. The block then drives the address latch enable, the code read strobe, the data read and write strobes, the shared low address/data byte, and the high address byte. It also returns the byte that the bus delivered.

Time is divided into slots of six oscillator clocks, which is half of a twelve-clock machine cycle. Fetch and idle slots last one slot. A data access lasts two slots. The address latch enable rises in the first two clocks of every slot, so a free-running bus shows it at one sixth of the oscillator rate. A data access drops the pulse that its second slot would have carried. A suppress input silences the idle and plain-fetch pulses but not those of table reads or data accesses.

A code fetch goes off-chip when the external-access pin was low during reset, or when the fetch address lies above the on-chip code top (0FFFH by default). The pin level is captured only while reset is held. An on-chip fetch leaves the bus idle: no code strobe, P0 released, and P2 showing the port register value.

Top module: `xbus_strobe_seq`

## Requirements
- R1: The request inputs are sampled on the clock edge that ends a slot, and `take` is high during that final clock. Idle and fetch slots last 6 clocks and data accesses last 12. Priority is read, then write, then fetch, then idle.
- R2: `ale` is high in clocks 0 and 1 of each idle or fetch slot unless suppressed, so a free-running bus pulses every 6 clocks.
- R3: A data access raises `ale` only in its clocks 0 and 1 and keeps it low in clocks 2 to 11, which drops the pulse of its second slot.
- R4: When `ale_off` is 1 at sampling, `ale` stays low for that idle or plain fetch slot. It still pulses for a fetch requested with `req_movc`=1 and for every data access.
- R5: `ea_pin` is latched on every clock while `rst` is high. Changes to it while out of reset have no effect on fetch routing.
- R6: A fetch is external when the latched pin is 0 or the address is above 0FFFH; otherwise it is internal.
- R7: An external fetch drives `psen_n` low in clocks 2 to 5. P0 carries the low address byte (`p0_oe`=1) in clocks 0 and 1 and is released in clocks 2 to 5. `p2_out` is the high address byte.
- R8: An internal fetch and an idle slot keep `psen_n`, `rd_n` and `wr_n` high, release P0, and show `p2_sfr` on `p2_out`.
- R9: A read drives `rd_n` low and a write drives `wr_n` low in clocks 2 to 9. Both put the low address byte on P0 in clocks 0 and 1. After that, a read releases P0 and a write drives `wdata` on it in clocks 2 to 11.
- R10: During a data access, `p2_out` is the high address byte when `wide`=1 and `p2_sfr` when `wide`=0.
- R11: `p0_in` is captured into `rdata` with `rvalid`=1 in clock 5 of an external fetch and in clock 9 of a read. `rvalid` is 0 in every other clock.
- R12: While `rst` is high, all three strobes are high, P0 is released, and `take` and `rvalid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| ea_pin | input | 1 | External-access pin, latched during reset |
| req_fetch | input | 1 | Code fetch request |
| req_movc | input | 1 | Qualifies a fetch as a table read from code space |
| req_rd | input | 1 | External data read request |
| req_wr | input | 1 | External data write request |
| wide | input | 1 | Data access uses a 16-bit address |
| addr | input | 16 | Fetch or data address |
| wdata | input | 8 | Write data |
| ale_off | input | 1 | Suppress address latch pulses in idle and plain fetch slots |
| p2_sfr | input | 8 | Port 2 register value |
| p0_in | input | 8 | Byte read back from the P0 pins |
| take | output | 1 | Final clock of the slot; requests are sampled at its end |
| ale | output | 1 | Address latch enable |
| psen_n | output | 1 | Code read strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| p0_out | output | 8 | Value driven on P0 |
| p0_oe | output | 1 | P0 drive enable |
| p2_out | output | 8 | Value on P2 |
| rdata | output | 8 | Last captured bus byte |
| rvalid | output | 1 | `rdata` updated this clock |

## Verification
The bench uses the default parameters: two clocks per state, a 6-clock slot, 8-bit bytes and a code top of 0FFFH. With these values the fetches at 0FFFH and 1000H land on both sides of the split, and one run covers slot lengths, strobe windows and the dropped pulse in a few hundred clocks. A second reset with the pin held low makes the fully external case reachable, and the pin is toggled after reset to show that routing does not follow it.

// File: rtl/xbus_strobe_seq.sv
module xbus_strobe_seq #(
  parameter int DW = 8,
  parameter int STATE_CLKS = 2,
  parameter logic [2*DW-1:0] INT_TOP = 16'h0FFF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ea_pin,
  input  logic          req_fetch,
  input  logic          req_movc,
  input  logic          req_rd,
  input  logic          req_wr,
  input  logic          wide,
  input  logic [2*DW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          ale_off,
  input  logic [DW-1:0] p2_sfr,
  input  logic [DW-1:0] p0_in,
  output logic          take,
  output logic          ale,
  output logic          psen_n,
  output logic          rd_n,
  output logic          wr_n,
  output logic [DW-1:0] p0_out,
  output logic          p0_oe,
  output logic [DW-1:0] p2_out,
  output logic [DW-1:0] rdata,
  output logic          rvalid
);
  localparam int AW    = 2 * DW;
  localparam int SLOT  = 3 * STATE_CLKS;
  localparam int DSLOT = 2 * SLOT;
  localparam int CW    = $clog2(DSLOT);
  localparam logic [CW-1:0] ADDR_END  = CW'(STATE_CLKS);
  localparam logic [CW-1:0] STRB_END  = CW'(DSLOT - STATE_CLKS);
  localparam logic [CW-1:0] SLOT_LAST = CW'(SLOT - 1);
  localparam logic [CW-1:0] DSLT_LAST = CW'(DSLOT - 1);
  localparam logic [CW-1:0] FCAP      = CW'(SLOT - 2);
  localparam logic [CW-1:0] DCAP      = CW'(DSLOT - STATE_CLKS - 2);

  typedef enum logic [2:0] {K_IDLE, K_FINT, K_FEXT, K_DRD, K_DWR} kind_t;

  logic [CW-1:0] cnt;
  kind_t         kind, nkind;
  logic [AW-1:0] a_q;
  logic [DW-1:0] wd_q;
  logic          wide_q, movc_q, aoff_q, ea_lat;

  wire data_op = (kind == K_DRD) || (kind == K_DWR);
  wire addr_ph = cnt < ADDR_END;
  wire strb_ph = !addr_ph && (cnt < STRB_END);
  wire cap     = (kind == K_FEXT && cnt == FCAP) || (kind == K_DRD && cnt == DCAP);

  assign take = (cnt == (data_op ? DSLT_LAST : SLOT_LAST));

  always_comb begin
    if (req_rd)                            nkind = K_DRD;
    else if (req_wr)                       nkind = K_DWR;
    else if (req_fetch && (!ea_lat || addr > INT_TOP)) nkind = K_FEXT;
    else if (req_fetch)                    nkind = K_FINT;
    else                                   nkind = K_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      kind   <= K_IDLE;
      a_q    <= '0;
      wd_q   <= '0;
      wide_q <= 1'b0;
      movc_q <= 1'b0;
      aoff_q <= 1'b0;
      ea_lat <= ea_pin;
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= cap;
      if (cap) rdata <= p0_in;
      if (take) begin
        cnt    <= '0;
        kind   <= nkind;
        a_q    <= addr;
        wd_q   <= wdata;
        wide_q <= wide;
        movc_q <= req_movc && req_fetch && !req_rd && !req_wr;
        aoff_q <= ale_off;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign ale    = addr_ph && (data_op || movc_q || !aoff_q);
  assign psen_n = !(kind == K_FEXT && !addr_ph);
  assign rd_n   = !(kind == K_DRD && strb_ph);
  assign wr_n   = !(kind == K_DWR && strb_ph);
  assign p0_oe  = (addr_ph && (kind == K_FEXT || data_op)) || (kind == K_DWR);
  assign p0_out = addr_ph ? a_q[DW-1:0] : wd_q;
  assign p2_out = (kind == K_FEXT || (data_op && wide_q)) ? a_q[AW-1:DW] : p2_sfr;

  // R7
  psen_busfree_chk: assert property (@(posedge clk) disable iff (rst) !psen_n |-> !p0_oe);
  // R9
  one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    $countones({~psen_n, ~rd_n, ~wr_n}) <= 1);
  // R3
  rd_after_ale_chk: assert property (@(posedge clk) disable iff (rst) $fell(rd_n) |-> $past(ale));
  // R3
  wr_after_ale_chk: assert property (@(posedge clk) disable iff (rst) $fell(wr_n) |-> $past(ale));
  // R5
  ea_hold_chk: assert property (@(posedge clk) disable iff (rst) $past(!rst) |-> $stable(ea_lat));
  // R6
  psen_route_chk: assert property (@(posedge clk) disable iff (rst)
    !psen_n |-> (!ea_lat || a_q > INT_TOP));
endmodule

// File: tb/xbus_strobe_seq_bench.sv
`timescale 1ns/1ps
module xbus_strobe_seq_bench;
  logic clk = 1'b0, rst = 1'b1, ea_pin = 1'b1;
  logic req_fetch = 0, req_movc = 0, req_rd = 0, req_wr = 0, wide = 0, ale_off = 0;
  logic [15:0] addr = '0;
  logic [7:0] wdata = '0, p2_sfr = 8'h5A, p0_in = '0;
  logic take, ale, psen_n, rd_n, wr_n, p0_oe, rvalid;
  logic [7:0] p0_out, p2_out, rdata;

  xbus_strobe_seq u_xbus_strobe_seq (.*);

  always #2 clk = ~clk;

  typedef struct {
    bit ale, psen_n, rd_n, wr_n, p0_oe, rv, tk;
    bit [7:0] p0, p2, rd;
  } rec_t;
  rec_t q[$];
  int vectors = 0, fails = 0;
  bit model_ea = 1;
  bit done = 0;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", what, act, exp, $time);
    end
  endtask

  task automatic compare(input rec_t r);
    vectors++;
    chk(take == r.tk, "R1 take", take, r.tk);
    chk(ale == r.ale, "R2/R3/R4 ale", ale, r.ale);
    chk(psen_n == r.psen_n, "R7/R8 psen_n", psen_n, r.psen_n);
    chk(rd_n == r.rd_n, "R9 rd_n", rd_n, r.rd_n);
    chk(wr_n == r.wr_n, "R9 wr_n", wr_n, r.wr_n);
    chk(p0_oe == r.p0_oe, "R7/R9 p0_oe", p0_oe, r.p0_oe);
    if (r.p0_oe) chk(p0_out == r.p0, "R7/R9 p0_out", p0_out, r.p0);
    chk(p2_out == r.p2, "R8/R10 p2_out", p2_out, r.p2);
    chk(rvalid == r.rv, "R11 rvalid", rvalid, r.rv);
    if (r.rv) chk(rdata == r.rd, "R11 rdata", rdata, r.rd);
  endtask

  task automatic expect_op();
    bit drd, dwr, fext, dat, mv;
    int len;
    drd  = req_rd;
    dwr  = !req_rd && req_wr;
    dat  = drd || dwr;
    fext = !dat && req_fetch && (!model_ea || addr > 16'h0FFF);
    mv   = !dat && req_fetch && req_movc;
    len  = dat ? 12 : 6;
    for (int c = 0; c < len; c++) begin
      rec_t r;
      r.ale    = (c < 2) && (dat || mv || !ale_off);
      r.psen_n = !(fext && c >= 2);
      r.rd_n   = !(drd && c >= 2 && c <= 9);
      r.wr_n   = !(dwr && c >= 2 && c <= 9);
      r.p0_oe  = ((c < 2) && (fext || dat)) || dwr;
      r.p0     = (c < 2) ? addr[7:0] : wdata;
      r.p2     = (fext || (dat && wide)) ? addr[15:8] : p2_sfr;
      r.rv     = (fext && c == 5) || (drd && c == 9);
      r.rd     = p0_in;
      r.tk     = (c == len - 1);
      q.push_back(r);
    end
  endtask

  task automatic drain();
    rec_t r;
    do begin
      r = q.pop_front();
      compare(r);
      if (!r.tk) @(negedge clk);
    end while (!r.tk);
  endtask

  task automatic issue(input bit rd, input bit wr, input bit f, input bit mv,
                       input logic [15:0] a, input logic [7:0] wd, input bit wd16,
                       input bit aoff, input logic [7:0] p2, input logic [7:0] pin);
    req_rd = rd; req_wr = wr; req_fetch = f; req_movc = mv; addr = a; wdata = wd;
    wide = wd16; ale_off = aoff; p2_sfr = p2; p0_in = pin;
    expect_op();
    @(negedge clk);
    drain();
  endtask

  task automatic do_reset(input bit ea);
    rst = 1; ea_pin = ea;
    req_rd = 0; req_wr = 0; req_fetch = 0; req_movc = 0; ale_off = 0;
    q.delete();
    repeat (4) @(negedge clk);
    // R12: reset state
    vectors++;
    chk(psen_n && rd_n && wr_n, "R12 strobes", {psen_n, rd_n, wr_n}, 3'b111);
    chk(!p0_oe, "R12 p0_oe", p0_oe, 0);
    chk(!take && !rvalid, "R12 take/rvalid", {take, rvalid}, 0);
    rst = 0; model_ea = ea;
    expect_op();
    drain();
  endtask

  initial begin
    do_reset(1'b1);
    // R8 R6: idle, internal fetch
    issue(0, 0, 0, 0, 16'h0000, 8'h00, 0, 0, 8'h5A, 8'h00);
    issue(0, 0, 1, 0, 16'h0123, 8'h00, 0, 0, 8'h5A, 8'h11);
    // R6 R7 R11: external fetch and the 0FFF/1000 split
    issue(0, 0, 1, 0, 16'h1234, 8'h00, 0, 0, 8'h5A, 8'h3C);
    issue(0, 0, 1, 0, 16'h0FFF, 8'h00, 0, 0, 8'h66, 8'h44);
    issue(0, 0, 1, 0, 16'h1000, 8'h00, 0, 0, 8'h66, 8'hC3);
    issue(0, 0, 1, 0, 16'hFFFF, 8'h00, 0, 0, 8'h66, 8'h81);
    // R4: suppress on idle and internal fetch; kept for table read and data
    issue(0, 0, 0, 0, 16'h0000, 8'h00, 0, 1, 8'h12, 8'h00);
    issue(0, 0, 1, 0, 16'h0200, 8'h00, 0, 1, 8'h12, 8'h00);
    issue(0, 0, 1, 1, 16'h2000, 8'h00, 0, 1, 8'h12, 8'h5E);
    issue(0, 0, 1, 1, 16'h0300, 8'h00, 0, 1, 8'h12, 8'h00);
    issue(0, 0, 1, 0, 16'h2001, 8'h00, 0, 1, 8'h12, 8'h00);
    // R3 R9 R10 R11: wide read, narrow write
    issue(1, 0, 0, 0, 16'hBEEF, 8'h00, 1, 1, 8'h21, 8'h77);
    issue(0, 1, 0, 0, 16'h0042, 8'hA5, 0, 0, 8'h99, 8'h00);
    issue(0, 1, 0, 0, 16'hC0DE, 8'h3B, 1, 0, 8'h99, 8'h00);
    issue(1, 0, 0, 0, 16'h0077, 8'h00, 0, 0, 8'hE4, 8'h9A);
    // R1: priority read > write > fetch
    issue(1, 1, 1, 0, 16'h4321, 8'hF0, 1, 0, 8'h01, 8'h2D);
    issue(0, 1, 1, 1, 16'h5555, 8'h0F, 1, 1, 8'h02, 8'h00);
    // R7: back-to-back external fetches, two code strobes per machine cycle
    issue(0, 0, 1, 0, 16'h8000, 8'h00, 0, 0, 8'h03, 8'hAA);
    issue(0, 0, 1, 0, 16'h8001, 8'h00, 0, 0, 8'h03, 8'h55);
    // R5: pin changes after reset are ignored
    ea_pin = 1'b0;
    issue(0, 0, 1, 0, 16'h0100, 8'h00, 0, 0, 8'h04, 8'h00);
    // R5 R6: latched low -> all fetches external
    do_reset(1'b0);
    issue(0, 0, 1, 0, 16'h0100, 8'h00, 0, 0, 8'h05, 8'h6B);
    issue(0, 0, 1, 0, 16'h0FFF, 8'h00, 0, 0, 8'h05, 8'h19);
    ea_pin = 1'b1;
    issue(0, 0, 1, 0, 16'h0000, 8'h00, 0, 0, 8'h06, 8'hF7);
    issue(0, 0, 0, 0, 16'h0000, 8'h00, 0, 0, 8'h06, 8'h00);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule